// File: doc/BRIEF.md
# Translation Mapping Replay Walker

This block rebuilds a downstream consumer's view of an I/O translation window. On a start pulse it samples a configuration: a page shift, a window size in bytes, and a skip flag. It then visits every page of the window in order, starting at I/O address zero and stepping by one page (one shifted left by the page shift). For each page it asks an external translation table for the entry. It forwards a mapping record only when the entry grants some access.

The lookup side is a simple request/response pair. A one-cycle request carries the page address, and the walker waits as long as needed for the single response that answers it. Records leave on a valid/ready stream. While a record is stalled, the scan stalls with it. The walk stops at the end of the window. It also stops at the last page below the top of the address space when one more step would wrap the address counter. A one-cycle done pulse marks the end of every walk, including one that is skipped or has an empty window.

Top module: `map_replay_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `rec_valid` and `lk_req_valid` are all 0.
- R2: After an accepted start, lookups are requested at addresses 0, S, 2S, ... where S = 1 << `cfg_page_shift`. Only addresses below `cfg_win_size` are requested. Each request lasts one cycle, and the next request is issued only after the previous response has been handled.
- R3: The permission is bits [1:0] of a looked-up entry, with 00 meaning no access. An entry with 00 produces no record. Entries with 01 (read), 10 (write) or 11 (both) produce exactly one record each, in address order.
- R4: A record carries `rec_iova` = the page address, `rec_xlat` = the entry with its low `cfg_page_shift` bits cleared, `rec_mask` = S-1, and `rec_perm` = entry bits [1:0].
- R5: While `rec_valid` is high and `rec_ready` is low, the record fields hold steady and no new lookup is requested.
- R6: If adding S to the current page address would carry past the top of the `ADDR_W`-bit address space, that page is the last one visited, even if `cfg_win_size` is larger.
- R7: A start with `cfg_skip` high issues no lookups and no records. `done` is pulsed in the next cycle.
- R8: `done` is high for exactly one cycle. That cycle follows the cycle that held the last of these events: the accepted start, the final lookup response, or the final record handshake. A window size of 0 behaves like a skipped walk.
- R9: A start while `busy` is ignored, and the configuration inputs are sampled only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| cfg_skip | input | 1 | Suppress the walk entirely |
| cfg_page_shift | input | SHIFT_W | log2 of the page size |
| cfg_win_size | input | ADDR_W+1 | Window size in bytes |
| lk_req_valid | output | 1 | Lookup request strobe |
| lk_req_addr | output | ADDR_W | Page address being looked up |
| lk_rsp_valid | input | 1 | Lookup response strobe |
| lk_rsp_entry | input | ADDR_W | Table entry; bits [1:0] are the permission |
| rec_valid | output | 1 | Mapping record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_iova | output | ADDR_W | I/O address of the page |
| rec_xlat | output | ADDR_W | Translated page address |
| rec_mask | output | ADDR_W | Offset mask within the page |
| rec_perm | output | 2 | Access permission |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
The assertions take three things for granted about the inputs. A lookup response arrives only while a request is outstanding. At most one response answers each request. The page shift offered with an accepted start is below the address width. The bench's table model honours the first two: it answers each request exactly once, after a latency of one to three cycles, and stays silent at all other times. The bench only ever drives shifts from 4 to 30 on a 32-bit configuration. The consumer's ready signal is driven both always high and as a pseudo-random pattern, so the stall rules are exercised under long and short stalls.

// File: rtl/rw_pkg.sv
package rw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_EMIT = 3'd3,
        ST_FIN  = 3'd4
    } rw_state_e;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_RD   = 2'b01;
    localparam logic [1:0] PERM_WR   = 2'b10;
    localparam logic [1:0] PERM_RW   = 2'b11;

endpackage

// File: rtl/rw_addr_gen.sv
// Page address counter: holds the walk position, the latched page shift and
// window, and flags the final page (window end or address-space wrap).
module rw_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               advance,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [ADDR_W:0]    cfg_win,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [SHIFT_W-1:0] cur_shift,
    output logic               last_page
);

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [SHIFT_W-1:0] shift;
        logic [ADDR_W:0]    win;
    } ag_state_t;

    ag_state_t ag_d, ag_q;

    logic [ADDR_W:0] step_w;
    logic [ADDR_W:0] next_w;
    logic            carry_out;

    always_comb begin
        step_w    = {{ADDR_W{1'b0}}, 1'b1} << ag_q.shift;
        next_w    = {1'b0, ag_q.addr} + step_w;
        carry_out = next_w[ADDR_W];
        last_page = carry_out || (next_w >= ag_q.win);

        ag_d = ag_q;
        if (load) begin
            ag_d.addr  = '0;
            ag_d.shift = cfg_shift;
            ag_d.win   = cfg_win;
        end else if (advance) begin
            ag_d.addr = next_w[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign cur_addr  = ag_q.addr;
    assign cur_shift = ag_q.shift;

    // R2: a step ordered by the sequencer always lands inside the window
    a_r2_step_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ({1'b0, ag_q.addr} < ag_q.win));

    // R6: a step never wraps the counter back towards zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ag_q.addr > $past(ag_q.addr)));

    // R2: counter restarts at zero on every load
    a_r2_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ag_q.addr == '0));

endmodule

// File: rtl/rw_rec_fmt.sv
// Turns a raw table entry plus its page address into record fields.
module rw_rec_fmt #(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0]  page_addr,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ADDR_W-1:0]  entry,
    output logic [ADDR_W-1:0]  iova,
    output logic [ADDR_W-1:0]  xlat,
    output logic [ADDR_W-1:0]  mask,
    output logic [1:0]         perm,
    output logic               populated
);

    import rw_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        mask      = (ONE << shift) - ONE;
        iova      = page_addr & ~mask;
        xlat      = entry & ~mask;
        perm      = entry[1:0];
        populated = (entry[1:0] != PERM_NONE);
    end

endmodule

// File: rtl/map_replay_walker.sv
module map_replay_walker #(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cfg_skip,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic [ADDR_W:0]    cfg_win_size,
    output logic               lk_req_valid,
    output logic [ADDR_W-1:0]  lk_req_addr,
    input  logic               lk_rsp_valid,
    input  logic [ADDR_W-1:0]  lk_rsp_entry,
    output logic               rec_valid,
    input  logic               rec_ready,
    output logic [ADDR_W-1:0]  rec_iova,
    output logic [ADDR_W-1:0]  rec_xlat,
    output logic [ADDR_W-1:0]  rec_mask,
    output logic [1:0]         rec_perm,
    output logic               busy,
    output logic               done
);

    import rw_pkg::*;

    typedef struct packed {
        rw_state_e         state;
        logic [ADDR_W-1:0] iova;
        logic [ADDR_W-1:0] xlat;
        logic [ADDR_W-1:0] mask;
        logic [1:0]        perm;
    } wk_state_t;

    wk_state_t wk_d, wk_q;

    logic               ag_load, ag_adv, ag_last;
    logic [ADDR_W-1:0]  ag_addr;
    logic [SHIFT_W-1:0] ag_shift;
    logic [ADDR_W-1:0]  f_iova, f_xlat, f_mask;
    logic [1:0]         f_perm;
    logic               f_pop;
    logic               page_done;

    rw_addr_gen #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .advance   (ag_adv),
        .cfg_shift (cfg_page_shift),
        .cfg_win   (cfg_win_size),
        .cur_addr  (ag_addr),
        .cur_shift (ag_shift),
        .last_page (ag_last)
    );

    rw_rec_fmt #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_fmt (
        .page_addr (ag_addr),
        .shift     (ag_shift),
        .entry     (lk_rsp_entry),
        .iova      (f_iova),
        .xlat      (f_xlat),
        .mask      (f_mask),
        .perm      (f_perm),
        .populated (f_pop)
    );

    always_comb begin
        wk_d      = wk_q;
        ag_load   = 1'b0;
        ag_adv    = 1'b0;
        page_done = 1'b0;

        unique case (wk_q.state)
            ST_IDLE: begin
                if (start) begin
                    ag_load = 1'b1;
                    if (cfg_skip || (cfg_win_size == '0)) begin
                        wk_d.state = ST_FIN;
                    end else begin
                        wk_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                wk_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (lk_rsp_valid) begin
                    if (f_pop) begin
                        wk_d.state = ST_EMIT;
                        wk_d.iova  = f_iova;
                        wk_d.xlat  = f_xlat;
                        wk_d.mask  = f_mask;
                        wk_d.perm  = f_perm;
                    end else begin
                        page_done = 1'b1;
                    end
                end
            end
            ST_EMIT: begin
                if (rec_ready) begin
                    page_done = 1'b1;
                end
            end
            ST_FIN: begin
                wk_d.state = ST_IDLE;
            end
            default: begin
                wk_d.state = ST_IDLE;
            end
        endcase

        if (page_done) begin
            if (ag_last) begin
                wk_d.state = ST_FIN;
            end else begin
                ag_adv     = 1'b1;
                wk_d.state = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q       <= '0;
            wk_q.state <= ST_IDLE;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign lk_req_valid = (wk_q.state == ST_REQ);
    assign lk_req_addr  = ag_addr;
    assign rec_valid    = (wk_q.state == ST_EMIT);
    assign rec_iova     = wk_q.iova;
    assign rec_xlat     = wk_q.xlat;
    assign rec_mask     = wk_q.mask;
    assign rec_perm     = wk_q.perm;
    assign busy         = (wk_q.state != ST_IDLE);
    assign done         = (wk_q.state == ST_FIN);

    // Input assumption: responses only answer an outstanding request
    a_r2_rsp_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid |-> (wk_q.state == ST_WAIT));

    // Input assumption: accepted shift fits the address width
    a_r2_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (int'(cfg_page_shift) < ADDR_W));

    // R2: requests are single-cycle strobes
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_valid |=> !lk_req_valid);

    // R3: every emitted record grants some access
    a_r3_rec_populated: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_perm != PERM_NONE));

    // R5: a stalled record holds steady and blocks further lookups
    a_r5_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_iova) &&
            $stable(rec_xlat) && $stable(rec_mask) && $stable(rec_perm)));

    a_r5_no_req_while_rec: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !lk_req_valid);

    // R7: a skipped start ends on the next cycle
    a_r7_skip_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_skip) |=> (done && !lk_req_valid));

    // R8: done is a single-cycle pulse followed by idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R4: record mask is an all-ones run from bit 0
    a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ((rec_mask & (rec_mask + 1'b1)) == '0));

endmodule

// File: tb/tb_map_replay_walker.sv
`timescale 1ns/1ps
module tb_map_replay_walker;

    localparam int AW = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          cfg_skip;
    logic [SW-1:0] cfg_page_shift;
    logic [AW:0]   cfg_win_size;
    logic          lk_req_valid;
    logic [AW-1:0] lk_req_addr;
    logic          lk_rsp_valid;
    logic [AW-1:0] lk_rsp_entry;
    logic          rec_valid;
    logic          rec_ready;
    logic [AW-1:0] rec_iova, rec_xlat, rec_mask;
    logic [1:0]    rec_perm;
    logic          busy, done;

    always #4 clk = ~clk;

    map_replay_walker #(.ADDR_W(AW), .SHIFT_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_skip(cfg_skip),
        .cfg_page_shift(cfg_page_shift), .cfg_win_size(cfg_win_size),
        .lk_req_valid(lk_req_valid), .lk_req_addr(lk_req_addr),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_entry(lk_rsp_entry),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_iova(rec_iova), .rec_xlat(rec_xlat), .rec_mask(rec_mask),
        .rec_perm(rec_perm), .busy(busy), .done(done)
    );

    typedef struct {
        logic [AW-1:0] iova;
        logic [AW-1:0] xlat;
        logic [AW-1:0] mask;
        logic [1:0]    perm;
    } rec_t;

    logic [AW-1:0] eq_addr[$];
    rec_t          eq_rec[$];

    int  n_chk = 0;
    int  n_err = 0;
    int  cyc = 0;
    int  last_evt = -10;
    bit  run_active = 0;
    bit  got_done = 0;
    bit  wd = 0;
    bit  rdy_always = 1;
    int  cur_shift = 12;
    int  cur_seed = 1;
    bit  held = 0;
    rec_t held_rec;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Table model: bits [1:0] of an entry are its permission (00 = none)
    function automatic logic [AW-1:0] tbl(logic [AW-1:0] a, int sh, int sd);
        logic [AW-1:0] v;
        logic [AW-1:0] pg;
        logic [1:0]    p;
        v  = (a ^ (sd * 32'h0101_3777)) * 32'd5 + 32'h0BAD_F00D;
        pg = a >> sh;
        p  = (sd == 0) ? 2'b00 : 2'(pg + AW'(sd) + (pg >> 2));
        return {v[AW-1:2], p};
    endfunction

    // Lookup responder: one answer per request, latency 1..3
    initial begin
        int lat_ctr = 0;
        lk_rsp_valid = 1'b0;
        lk_rsp_entry = '0;
        forever begin
            @(posedge clk); #1;
            lk_rsp_valid = 1'b0;
            if (rst_n && lk_req_valid) begin
                logic [AW-1:0] a;
                int lat;
                a = lk_req_addr;
                lat = 1 + (lat_ctr % 3);
                lat_ctr++;
                repeat (lat) begin @(posedge clk); #1; end
                lk_rsp_valid = 1'b1;
                lk_rsp_entry = tbl(a, cur_shift, cur_seed);
            end
        end
    end

    // Consumer ready pattern
    initial begin
        logic [7:0] lfsr = 8'hA7;
        rec_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rec_ready = rdy_always ? 1'b1 : (lfsr[0] & lfsr[2]);
        end
    end

    // Reference model compared every cycle
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000 && !wd) begin
                wd = 1;
                n_chk++; n_err++;
                $display("FAIL R8 watchdog: actual=%0d expected=<150000", cyc);
            end
            if (!rst_n) begin
                chk("R1", "busy in reset", busy, 0);
                chk("R1", "done in reset", done, 0);
                chk("R1", "rec_valid in reset", rec_valid, 0);
                chk("R1", "lk_req_valid in reset", lk_req_valid, 0);
            end else begin
                bit exp_done;
                exp_done = run_active && (eq_addr.size() == 0) &&
                           (eq_rec.size() == 0) && (cyc == last_evt + 1);
                chk("R8", "done", done, exp_done);
                if (done) begin
                    run_active = 0;
                    got_done = 1;
                end
                if (start && !busy) last_evt = cyc;
                if (lk_req_valid) begin
                    chk("R5", "request during stalled record", held, 0);
                    if (eq_addr.size() == 0) begin
                        chk("R2", "unexpected request addr", lk_req_addr, 64'hDEAD);
                    end else begin
                        chk("R2", "request addr", lk_req_addr, eq_addr.pop_front());
                    end
                end
                if (lk_rsp_valid) last_evt = cyc;
                if (rec_valid) begin
                    if (held) begin
                        chk("R5", "held iova", rec_iova, held_rec.iova);
                        chk("R5", "held xlat", rec_xlat, held_rec.xlat);
                        chk("R5", "held perm", rec_perm, held_rec.perm);
                    end
                    if (rec_ready) begin
                        held = 0;
                        last_evt = cyc;
                        if (eq_rec.size() == 0) begin
                            chk("R3", "unexpected record", rec_iova, 64'hDEAD);
                        end else begin
                            rec_t e;
                            e = eq_rec.pop_front();
                            chk("R4", "iova", rec_iova, e.iova);
                            chk("R4", "xlat", rec_xlat, e.xlat);
                            chk("R4", "mask", rec_mask, e.mask);
                            chk("R3", "perm", rec_perm, e.perm);
                        end
                    end else begin
                        held = 1;
                        held_rec.iova = rec_iova;
                        held_rec.xlat = rec_xlat;
                        held_rec.mask = rec_mask;
                        held_rec.perm = rec_perm;
                    end
                end else begin
                    held = 0;
                end
            end
        end
    end

    task automatic run_walk(int sh, logic [AW:0] win, bit skip, int sd,
                            bit rnd_ready, bit poke_busy, string req);
        longint step;
        longint a;
        step = longint'(1) << sh;
        eq_addr.delete();
        eq_rec.delete();
        if (!skip) begin
            for (a = 0; a < longint'(win); a += step) begin
                logic [AW-1:0] ent;
                eq_addr.push_back(AW'(a));
                ent = tbl(AW'(a), sh, sd);
                if (ent[1:0] != 2'b00) begin
                    rec_t r;
                    r.iova = AW'(a);
                    r.mask = AW'(step - 1);
                    r.xlat = ent & ~r.mask;
                    r.perm = ent[1:0];
                    eq_rec.push_back(r);
                end
                if (a + step >= (longint'(1) << AW)) break;
            end
        end
        cur_shift  = sh;
        cur_seed   = sd;
        rdy_always = !rnd_ready;
        @(posedge clk); #1;
        cfg_page_shift = SW'(sh);
        cfg_win_size   = win;
        cfg_skip       = skip;
        start          = 1'b1;
        run_active     = 1;
        got_done       = 0;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke_busy) begin
            repeat (3) begin @(posedge clk); #1; end
            cfg_page_shift = 5'd4;
            cfg_win_size   = 33'h40;
            cfg_skip       = 1'b1;
            start          = 1'b1;
            @(posedge clk); #1;
            start          = 1'b0;
        end
        while (!got_done && !wd) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(req, "leftover lookups", eq_addr.size(), 0);
        chk(req, "leftover records", eq_rec.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        cfg_skip = 1'b0;
        cfg_page_shift = '0;
        cfg_win_size = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_walk(12, 33'(16 << 12), 0, 1, 0, 0, "R2");          // R2 R3 R4 basic
        if (!wd) run_walk(12, 33'((10 << 12) + 5), 0, 2, 1, 0, "R5"); // partial page, stalls
        if (!wd) run_walk(4, 33'h1000, 0, 3, 1, 0, "R4");       // small pages
        if (!wd) run_walk(8, 33'h800, 0, 0, 0, 0, "R3");        // all entries empty
        if (!wd) run_walk(12, 33'h10000, 1, 1, 0, 0, "R7");     // skip
        if (!wd) run_walk(12, 33'h0, 0, 1, 0, 0, "R8");         // empty window
        if (!wd) run_walk(30, 33'h1_FFFF_FFFF, 0, 5, 1, 0, "R6"); // wrap stop
        if (!wd) run_walk(30, 33'h1_0000_0000, 0, 6, 0, 0, "R6"); // full space
        if (!wd) run_walk(10, 33'(24 << 10), 0, 7, 1, 1, "R9"); // start while busy

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule